// File: doc/BRIEF.md
# Lockable Host Configuration Address Decoder

This block decides whether a host I/O cycle falls on the configuration index/data register pair and raises a hit for each of the two locations. When the programmable mode input is low, a strap input picks one of two fixed base addresses. When the mode input is high, the base comes from two byte-wide registers that firmware loads. A valid flag and a lock bit guard those registers.

Firmware loads a new base in four steps. It clears the valid flag by writing 1 to it, writes the low byte, writes the high byte, and then sets the lock. A small state machine follows this sequence. Its states are EMPTY (no usable base), LOW_HELD (low byte written, high byte pending), VALID (usable base, unlocked), LOCKED (usable base, frozen) and DEAD (locked with no usable base).

The named transitions are:
- EMPTY→LOW_HELD on a low write.
- LOW_HELD→VALID on a high write.
- VALID→LOW_HELD on a low write.
- VALID→EMPTY on a valid clear.
- VALID→LOCKED on a lock write.
- VALID→DEAD on a lock write combined with a valid clear.
- EMPTY or LOW_HELD→DEAD on a lock write.

LOCKED and DEAD are left only through the power-up reset, which is also the only reset of the block's state.

Top module: `hcfg_addr_unit`

## Requirements
- R1: After power-up reset the low byte, the high byte, the valid flag and the lock bit all read 0.
- R2: With programmable mode low, strap 0 selects base 0x002E and strap 1 selects base 0x004E. The index hit is raised at the base and the data hit at base+1, whatever the valid flag holds.
- R3: With programmable mode high and the valid flag clear, neither hit is raised for any host address.
- R4: The valid flag sets on a high-byte write that follows a low-byte write while the lock is clear. A high-byte write without a preceding low-byte write stores the byte but leaves valid clear.
- R5: A low-byte write with bit 7 of the data set is ignored, and the stored low byte and the valid flag are unchanged.
- R6: Writing control bit 0 as 1 clears valid while unlocked, and writing it as 0 has no effect.
- R7: A low-byte write while valid is set clears valid until the next high-byte write.
- R8: Writing control bit 1 as 1 sets the lock, which stays set until power-up reset. While locked, writes to both address bytes and to the valid clear are ignored.
- R9: With programmable mode high and valid set, the index hit is raised only for an I/O cycle at the base and the data hit only for an I/O cycle at base+1. Other addresses and non-I/O cycles give no hit.
- R10: Register map: offset 0 is the low byte, offset 1 the high byte, offset 2 control (bit 0 valid, bit 1 lock, other bits read 0), and offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-up reset, the only reset of the block's state |
| prog_mode | input | 1 | 1 selects the firmware-loaded base, 0 the strap default |
| strap_sel | input | 1 | Picks one of the two fixed defaults |
| fw_wr | input | 1 | Firmware write strobe, one cycle per write |
| fw_addr | input | 2 | Firmware register offset |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Firmware read data at fw_addr, combinational |
| host_io | input | 1 | Current host cycle is an I/O cycle |
| host_addr | input | 16 | Host cycle address |
| hit_idx | output | 1 | Host cycle targets the index register |
| hit_dat | output | 1 | Host cycle targets the data register |

## Verification
A firmware write takes effect at the first rising edge that samples the strobe. The bench drives each write on a falling edge, removes it on the next falling edge, and only then reads back registers or probes hits. Read data and both hit outputs are combinational, with zero cycles of latency from their inputs. The bench therefore sets host inputs on a falling edge and samples one time unit later, well before the next rising edge. For several firmware-loaded bases, it sweeps every host address from base-2 to base+3 with I/O asserted and again with it deasserted, and computes the expected hits arithmetically.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int OFS_W  = 2;

    localparam logic [OFS_W-1:0] OFS_LOW  = 2'd0;
    localparam logic [OFS_W-1:0] OFS_HIGH = 2'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 2'd2;

    localparam int CTRL_VALID_BIT = 0;
    localparam int CTRL_LOCK_BIT  = 1;

    typedef enum logic [2:0] {
        ST_EMPTY    = 3'd0,
        ST_LOW_HELD = 3'd1,
        ST_VALID    = 3'd2,
        ST_LOCKED   = 3'd3,
        ST_DEAD     = 3'd4
    } hcfg_state_e;
endpackage

// File: rtl/hcfg_ctl.sv
module hcfg_ctl
    import hcfg_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              fw_wr,
    input  logic [OFS_W-1:0]  fw_addr,
    input  logic [BYTE_W-1:0] fw_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic              valid,
    output logic              locked
);
    hcfg_state_e state_q, state_d;
    logic wr_low_ok, wr_high, wr_ctrl, clr_req, lock_req, open_regs;

    assign open_regs = (state_q != ST_LOCKED) && (state_q != ST_DEAD);
    assign wr_low_ok = fw_wr && (fw_addr == OFS_LOW) && !fw_wdata[BYTE_W-1] && open_regs;
    assign wr_high   = fw_wr && (fw_addr == OFS_HIGH) && open_regs;
    assign wr_ctrl   = fw_wr && (fw_addr == OFS_CTRL);
    assign clr_req   = wr_ctrl && fw_wdata[CTRL_VALID_BIT];
    assign lock_req  = wr_ctrl && fw_wdata[CTRL_LOCK_BIT];

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (lock_req)       state_d = ST_DEAD;
                else if (wr_low_ok) state_d = ST_LOW_HELD;
            end
            ST_LOW_HELD: begin
                if (lock_req)     state_d = ST_DEAD;
                else if (wr_high) state_d = ST_VALID;
            end
            ST_VALID: begin
                if (lock_req)       state_d = clr_req ? ST_DEAD : ST_LOCKED;
                else if (clr_req)   state_d = ST_EMPTY;
                else if (wr_low_ok) state_d = ST_LOW_HELD;
            end
            ST_LOCKED: state_d = ST_LOCKED;
            ST_DEAD:   state_d = ST_DEAD;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // address byte registers
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            base_q <= '0;
        end else begin
            if (wr_low_ok) base_q[BYTE_W-1:0]      <= fw_wdata;
            if (wr_high)   base_q[ADDR_W-1:BYTE_W] <= fw_wdata;
        end
    end

    // outputs
    always_comb begin
        valid  = (state_q == ST_VALID) || (state_q == ST_LOCKED);
        locked = (state_q == ST_LOCKED) || (state_q == ST_DEAD);
    end

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> (locked && $stable(base_q) && $stable(valid)));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(valid) |-> $past(fw_wr && fw_addr == OFS_HIGH));

    // R5
    low_bit7_chk: assert property (@(posedge clk) disable iff (!por_n)
        (fw_wr && fw_addr == OFS_LOW && fw_wdata[BYTE_W-1]) |=> $stable(base_q[BYTE_W-1:0]));
endmodule

// File: rtl/hcfg_dec.sv
module hcfg_dec
    import hcfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEF_BASE0 = 16'h002E,
    parameter logic [ADDR_W-1:0] DEF_BASE1 = 16'h004E
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              prog_mode,
    input  logic              strap_sel,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              valid,
    input  logic              host_io,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              hit_idx,
    output logic              hit_dat
);
    logic [ADDR_W-1:0] eff_base, data_loc;
    logic              enable;

    always_comb begin
        eff_base = prog_mode ? base_q : (strap_sel ? DEF_BASE1 : DEF_BASE0);
        data_loc = eff_base + ADDR_W'(1);
        enable   = host_io && (!prog_mode || valid);
        hit_idx  = enable && (host_addr == eff_base);
        hit_dat  = enable && (host_addr == data_loc);
    end

    // R3
    no_claim_chk: assert property (@(posedge clk) disable iff (!por_n)
        (prog_mode && !valid) |-> !(hit_idx || hit_dat));

    // R9
    io_only_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hit_idx || hit_dat) |-> (host_io && !(hit_idx && hit_dat)));
endmodule

// File: rtl/hcfg_addr_unit.sv
module hcfg_addr_unit
    import hcfg_pkg::*;
#(
    parameter logic [15:0] DEF_BASE0 = 16'h002E,
    parameter logic [15:0] DEF_BASE1 = 16'h004E
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        prog_mode,
    input  logic        strap_sel,
    input  logic        fw_wr,
    input  logic [1:0]  fw_addr,
    input  logic [7:0]  fw_wdata,
    output logic [7:0]  fw_rdata,
    input  logic        host_io,
    input  logic [15:0] host_addr,
    output logic        hit_idx,
    output logic        hit_dat
);
    logic [ADDR_W-1:0] base_q;
    logic              valid, locked;

    hcfg_ctl u_ctl (
        .clk(clk), .por_n(por_n), .fw_wr(fw_wr), .fw_addr(fw_addr),
        .fw_wdata(fw_wdata), .base_q(base_q), .valid(valid), .locked(locked)
    );

    hcfg_dec #(.DEF_BASE0(DEF_BASE0), .DEF_BASE1(DEF_BASE1)) u_dec (
        .clk(clk), .por_n(por_n), .prog_mode(prog_mode), .strap_sel(strap_sel),
        .base_q(base_q), .valid(valid), .host_io(host_io), .host_addr(host_addr),
        .hit_idx(hit_idx), .hit_dat(hit_dat)
    );

    always_comb begin
        fw_rdata = '0;
        unique case (fw_addr)
            OFS_LOW:  fw_rdata = base_q[BYTE_W-1:0];
            OFS_HIGH: fw_rdata = base_q[ADDR_W-1:BYTE_W];
            OFS_CTRL: begin
                fw_rdata[CTRL_VALID_BIT] = valid;
                fw_rdata[CTRL_LOCK_BIT]  = locked;
            end
            default:  fw_rdata = '0;
        endcase
    end
endmodule

// File: tb/hcfg_addr_unit_bench.sv
module hcfg_addr_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, por_n = 0, prog_mode = 0, strap_sel = 0;
    logic        fw_wr = 0, host_io = 0;
    logic [1:0]  fw_addr = 0;
    logic [7:0]  fw_wdata = 0, fw_rdata;
    logic [15:0] host_addr = 0;
    logic        hit_idx, hit_dat;
    int          n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcfg_addr_unit u_hcfg_addr_unit (
        .clk(clk), .por_n(por_n), .prog_mode(prog_mode), .strap_sel(strap_sel),
        .fw_wr(fw_wr), .fw_addr(fw_addr), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
        .host_io(host_io), .host_addr(host_addr), .hit_idx(hit_idx), .hit_dat(hit_dat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        fw_wr = 1; fw_addr = a; fw_wdata = d;
        @(negedge clk);
        fw_wr = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        fw_addr = a; #1;
        chk(fw_rdata == exp, req, fw_rdata, exp);
    endtask

    // expected hits computed arithmetically
    task automatic probe(input logic [15:0] a, input logic io, input logic [15:0] base,
                         input logic en, input string req);
        logic ei, ed;
        host_addr = a; host_io = io; #1;
        ei = en && io && (a == base);
        ed = en && io && (a == 16'(base + 16'd1));
        chk({hit_idx, hit_dat} == {ei, ed}, req, {hit_idx, hit_dat}, {ei, ed});
    endtask

    task automatic sweep(input logic [15:0] base, input logic en, input string req);
        for (int off = -2; off <= 3; off++) begin
            for (int io = 0; io < 2; io++)
                probe(16'(int'(base) + off), io[0], base, en, req);
        end
    endtask

    task automatic por();
        por_n = 0; #(2*CLK_PERIOD); @(negedge clk); por_n = 1;
    endtask

    initial begin
        #(200000*CLK_PERIOD);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        por();
        // R1 / R10
        rd_chk(2'd0, 8'h00, "R1 low");
        rd_chk(2'd1, 8'h00, "R1 high");
        rd_chk(2'd2, 8'h00, "R1 ctrl");
        rd_chk(2'd3, 8'h00, "R10 offset3");

        // R2 strap defaults
        prog_mode = 0; strap_sel = 0; sweep(16'h002E, 1'b1, "R2 strap0");
        strap_sel = 1; sweep(16'h004E, 1'b1, "R2 strap1");

        // R3 no valid
        prog_mode = 1;
        sweep(16'h0000, 1'b0, "R3 base0");
        sweep(16'h004E, 1'b0, "R3 strapaddr");

        // R4 high without low
        wr(2'd1, 8'h12);
        rd_chk(2'd1, 8'h12, "R4 high stored");
        rd_chk(2'd2, 8'h00, "R4 no valid");

        // R5 bit7 rejected
        wr(2'd0, 8'h85);
        rd_chk(2'd0, 8'h00, "R5 low kept");
        rd_chk(2'd2, 8'h00, "R5 valid kept");

        // several bases, full sequence
        for (int i = 0; i < 6; i++) begin
            logic [15:0] b;
            b = 16'(i * 16'h2B35 + 16'h0101) & 16'hFF7F;
            wr(2'd2, 8'h01);
            wr(2'd0, b[7:0]);
            rd_chk(2'd2, 8'h00, "R4 valid after low only");
            sweep(b, 1'b0, "R3 pending");
            wr(2'd1, b[15:8]);
            rd_chk(2'd2, 8'h01, "R4 valid set");
            rd_chk(2'd0, b[7:0], "R10 low readback");
            rd_chk(2'd1, b[15:8], "R10 high readback");
            sweep(b, 1'b1, "R9 decode");
        end

        // R6 writing 0 no effect, writing 1 clears
        wr(2'd2, 8'h00);
        rd_chk(2'd2, 8'h01, "R6 write0");
        wr(2'd2, 8'h01);
        rd_chk(2'd2, 8'h00, "R6 clear");

        // R7 low write while valid
        wr(2'd0, 8'h40); wr(2'd1, 8'h03);
        rd_chk(2'd2, 8'h01, "R7 setup");
        wr(2'd0, 8'h44);
        rd_chk(2'd2, 8'h00, "R7 dropped");
        sweep(16'h0344, 1'b0, "R7 no hits");
        wr(2'd1, 8'h05);
        rd_chk(2'd2, 8'h01, "R7 revalid");
        sweep(16'h0544, 1'b1, "R7 decode");

        // R8 lock
        wr(2'd2, 8'h02);
        rd_chk(2'd2, 8'h03, "R8 locked");
        wr(2'd0, 8'h10); wr(2'd1, 8'h20); wr(2'd2, 8'h01); wr(2'd2, 8'h00);
        rd_chk(2'd0, 8'h44, "R8 low frozen");
        rd_chk(2'd1, 8'h05, "R8 high frozen");
        rd_chk(2'd2, 8'h03, "R8 stays");
        sweep(16'h0544, 1'b1, "R8 decode");
        prog_mode = 0; strap_sel = 0;
        sweep(16'h002E, 1'b1, "R2 default while locked");

        // R8 lock with no valid, then R1 after POR
        por(); prog_mode = 1;
        rd_chk(2'd2, 8'h00, "R1 after por");
        rd_chk(2'd0, 8'h00, "R1 low after por");
        wr(2'd0, 8'h22); wr(2'd2, 8'h02); wr(2'd1, 8'h33);
        rd_chk(2'd2, 8'h02, "R8 dead");
        rd_chk(2'd1, 8'h00, "R8 high blocked");
        sweep(16'h0022, 1'b0, "R3 dead");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule